// File: doc/BRIEF.md
# Burst Target for a Multiplexed Address/Data Bus

This block is the slave side of a synchronous 32-bit parallel bus where address and data share the same lines. It watches every transaction start. On the start cycle it captures the address and the 4-bit command. It claims the transaction when the command and the address fall inside one of its two local windows: a memory window and an I/O window. Both windows are backed by a small local register file.

Once it has claimed a transaction, the target runs one or more data phases. Each phase finishes only when both sides signal ready. In memory space the word index steps up after every completed phase. When a burst would run past the end of the memory window, the target signals stop on the last valid word. I/O accesses always end after a single word. Bus control lines are active low. Reads present the addressed word on a separate output with an enable, and writes honour per-byte enables.

Top module: `mux_bus_target`

## Requirements
- R1: While reset is high and on the cycle after it falls, claim_n, target_ready_n and stop_req_n are 1 and addr_data_oe is 0. Every register-file word reads back as zero after reset.
- R2: A start cycle is a cycle with bus_cyc_n low while the target is idle. On the cycle after a start cycle the target drives claim_n and target_ready_n low if the command qualifies. Memory commands qualify inside the memory window: read codes 4'b0110, 4'b1100, 4'b1110 and write codes 4'b0111, 4'b1111. I/O commands qualify inside the I/O window: read 4'b0010, write 4'b0011. During a claimed read, addr_data_oe is 1 and addr_data_out carries the addressed word.
- R3: The target never claims any other command code, which includes the reserved codes 4'b0100 and 4'b1000. It does not claim an address outside the selected window. An unclaimed access leaves the register file unchanged.
- R4: A data phase completes only on a clock edge where init_ready_n and target_ready_n are both low. While init_ready_n is high, no write happens and the word index holds.
- R5: In a data phase, cmd_be_n[b] low enables byte b (bits 8b+7:8b) of a write. Disabled bytes keep their old value.
- R6: A phase that completes with bus_cyc_n high is the final one. On the next cycle claim_n, target_ready_n and stop_req_n are all 1.
- R7: In memory space, each completed non-final phase advances the word index by one. The window base maps to index 0, and address bits 1:0 are ignored.
- R8: While the current word is the last word of the memory window, stop_req_n is low together with target_ready_n. If that phase completes with bus_cyc_n still low, the target then holds claim_n and stop_req_n low with target_ready_n high until bus_cyc_n goes high.
- R9: Every I/O data phase shows stop_req_n low, so a burst attempt in I/O space ends after its first word.
- R10: Codes 4'b1100 and 4'b1110 read exactly like 4'b0110, and code 4'b1111 writes exactly like 4'b0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc_n | input | 1 | Low for the whole duration of a transaction |
| init_ready_n | input | 1 | Initiator ready, active low |
| addr_data_in | input | 32 | Address on the start cycle, write data in data phases |
| cmd_be_n | input | 4 | Command on the start cycle, active-low byte enables in data phases |
| addr_data_out | output | 32 | Read data of the current word |
| addr_data_oe | output | 1 | High while read data is driven |
| claim_n | output | 1 | Transaction claimed, active low |
| target_ready_n | output | 1 | Target ready for the current data phase, active low |
| stop_req_n | output | 1 | Target requests termination, active low |

## Verification
The bench builds the default configuration: an 8-word memory window at 0x1000 and a 4-word I/O window at 0x300, 12 register words in total. With so few words, the bench can start a burst at every memory offset, so the window-end disconnect and the hold state that follows it are reached from every position. It also sweeps all 16 byte-enable patterns on one word and all 16 command codes against both windows. Expected words come from a model array in the bench that applies byte-lane arithmetic, and wait states are inserted on alternate bursts.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_HOLD,
        ST_SKIP
    } bt_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_MEM_RD,
        K_MEM_WR,
        K_IO_RD,
        K_IO_WR
    } bt_kind_e;

    typedef struct packed {
        logic hit;
        logic write;
        logic io;
    } bt_claim_s;

    localparam logic [3:0] CMD_IO_RD       = 4'h2;
    localparam logic [3:0] CMD_IO_WR       = 4'h3;
    localparam logic [3:0] CMD_MEM_RD      = 4'h6;
    localparam logic [3:0] CMD_MEM_WR      = 4'h7;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'hC;
    localparam logic [3:0] CMD_MEM_RD_LINE = 4'hE;
    localparam logic [3:0] CMD_MEM_WR_INV  = 4'hF;

    // Classify a bus command; anything not listed is never claimed.
    function automatic bt_kind_e cmd_kind(input logic [3:0] c);
        case (c)
            CMD_IO_RD:                                      return K_IO_RD;
            CMD_IO_WR:                                      return K_IO_WR;
            CMD_MEM_RD, CMD_MEM_RD_MULT, CMD_MEM_RD_LINE:   return K_MEM_RD;
            CMD_MEM_WR, CMD_MEM_WR_INV:                     return K_MEM_WR;
            default:                                        return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bt_decode.sv
module bt_decode
    import bt_pkg::*;
#(
    parameter logic [31:0] MEM_BASE  = 32'h0000_1000,
    parameter int          MEM_WORDS = 8,
    parameter logic [31:0] IO_BASE   = 32'h0000_0300,
    parameter int          IO_WORDS  = 4,
    parameter int          IDXW      = 4
) (
    input  logic [31:0]     addr,
    input  logic [3:0]      cmd,
    output bt_claim_s       claim,
    output logic [IDXW-1:0] start_idx
);
    localparam logic [31:0] MEM_BYTES = 32'(MEM_WORDS * 4);
    localparam logic [31:0] IO_BYTES  = 32'(IO_WORDS * 4);

    logic [31:0] mem_off;
    logic [31:0] io_off;
    logic        in_mem;
    logic        in_io;
    bt_kind_e    kind;
    logic        mem_hit;
    logic        io_hit;

    always_comb begin
        mem_off = addr - MEM_BASE;
        io_off  = addr - IO_BASE;
        in_mem  = mem_off < MEM_BYTES;
        in_io   = io_off < IO_BYTES;
        kind    = cmd_kind(cmd);
        mem_hit = in_mem && (kind == K_MEM_RD || kind == K_MEM_WR);
        io_hit  = in_io && (kind == K_IO_RD || kind == K_IO_WR);

        claim.hit   = mem_hit || io_hit;
        claim.io    = io_hit;
        claim.write = (mem_hit && kind == K_MEM_WR) || (io_hit && kind == K_IO_WR);

        if (io_hit) start_idx = IDXW'(MEM_WORDS) + io_off[IDXW+1:2];
        else        start_idx = mem_off[IDXW+1:2];
    end

    // R3: reserved codes never produce a claim
    always_comb begin
        if (cmd == 4'b0100 || cmd == 4'b1000)
            a_r3_reserved_unclaimed: assert (!claim.hit);
    end

endmodule

// File: rtl/bt_regfile.sv
module bt_regfile #(
    parameter int WORDS = 12,
    parameter int IDXW  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [31:0]     wr_data,
    input  logic [3:0]      wr_be,
    input  logic [IDXW-1:0] rd_idx,
    output logic [31:0]     rd_data
);
    logic [31:0] words [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [31:0] word_q;
        logic        sel;

        assign sel = wr_en && (wr_idx == IDXW'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (sel) begin
                for (int b = 0; b < 4; b++) begin
                    if (wr_be[b]) word_q[8*b +: 8] <= wr_data[8*b +: 8];
                end
            end
        end

        assign words[w] = word_q;

        // R5: a disabled lane keeps its value across a write
        a_r5_lane_kept: assert property (@(posedge clk) disable iff (rst)
            (sel && !wr_be[0]) |=> $stable(word_q[7:0]));
    end

    always_comb begin
        if (int'(rd_idx) < WORDS) rd_data = words[rd_idx];
        else                      rd_data = '0;
    end

endmodule

// File: rtl/bt_phase_ctl.sv
module bt_phase_ctl
    import bt_pkg::*;
#(
    parameter int MEM_WORDS = 8,
    parameter int IDXW      = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_cyc_n,
    input  logic            init_ready_n,
    input  bt_claim_s       start_claim,
    input  logic [IDXW-1:0] start_idx,
    output logic            claim_n,
    output logic            target_ready_n,
    output logic            stop_req_n,
    output logic            read_oe,
    output logic            wr_en,
    output logic [IDXW-1:0] cur_idx
);
    localparam logic [IDXW-1:0] LAST_MEM = IDXW'(MEM_WORDS - 1);

    bt_state_e state_q;
    bt_state_e state_d;
    bt_claim_s claim_q;
    logic [IDXW-1:0] idx_d;
    logic      in_data;
    logic      at_edge;
    logic      done;

    always_comb begin
        in_data = (state_q == ST_DATA);
        at_edge = in_data && (claim_q.io || cur_idx == LAST_MEM);
        done    = in_data && !init_ready_n;
        state_d = state_q;
        idx_d   = cur_idx;
        case (state_q)
            ST_IDLE: begin
                if (!bus_cyc_n) begin
                    state_d = start_claim.hit ? ST_DATA : ST_SKIP;
                    idx_d   = start_idx;
                end
            end
            ST_DATA: begin
                if (done) begin
                    if (bus_cyc_n)    state_d = ST_IDLE;
                    else if (at_edge) state_d = ST_HOLD;
                    else              idx_d   = cur_idx + 1'b1;
                end
            end
            ST_HOLD, ST_SKIP: begin
                if (bus_cyc_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            claim_q <= '0;
            cur_idx <= '0;
        end else begin
            state_q <= state_d;
            cur_idx <= idx_d;
            if (state_q == ST_IDLE && !bus_cyc_n) claim_q <= start_claim;
        end
    end

    assign claim_n        = !(in_data || state_q == ST_HOLD);
    assign target_ready_n = !in_data;
    assign stop_req_n     = !(at_edge || state_q == ST_HOLD);
    assign read_oe        = in_data && !claim_q.write;
    assign wr_en          = done && claim_q.write;

    // R4: a ready target is always a claiming target
    a_r4_ready_claimed: assert property (@(posedge clk) disable iff (rst)
        !target_ready_n |-> !claim_n);

    // R4: without initiator ready the phase stays open at the same word
    a_r4_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (in_data && init_ready_n) |=> (state_q == ST_DATA && cur_idx == $past(cur_idx)));

    // R6: final phase releases every indication
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (!target_ready_n && !init_ready_n && bus_cyc_n) |=> (claim_n && target_ready_n && stop_req_n));

    // R7: a completed non-final phase without stop moves to the next word
    a_r7_advance: assert property (@(posedge clk) disable iff (rst)
        (!target_ready_n && !init_ready_n && !bus_cyc_n && stop_req_n)
        |=> (cur_idx == $past(cur_idx) + 1'b1));

    // R8: stop with data continues as stop without ready
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!target_ready_n && !init_ready_n && !bus_cyc_n && !stop_req_n)
        |=> (target_ready_n && !stop_req_n && !claim_n));

    // R9: an I/O phase never continues into a second ready phase
    a_r9_io_single: assert property (@(posedge clk) disable iff (rst)
        (in_data && claim_q.io && !init_ready_n) |=> target_ready_n);

endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target
    import bt_pkg::*;
#(
    parameter logic [31:0] MEM_BASE  = 32'h0000_1000,
    parameter int          MEM_WORDS = 8,
    parameter logic [31:0] IO_BASE   = 32'h0000_0300,
    parameter int          IO_WORDS  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_cyc_n,
    input  logic        init_ready_n,
    input  logic [31:0] addr_data_in,
    input  logic [3:0]  cmd_be_n,
    output logic [31:0] addr_data_out,
    output logic        addr_data_oe,
    output logic        claim_n,
    output logic        target_ready_n,
    output logic        stop_req_n
);
    localparam int WORDS = MEM_WORDS + IO_WORDS;
    localparam int IDXW  = $clog2(WORDS);

    bt_claim_s       start_claim;
    logic [IDXW-1:0] start_idx;
    logic [IDXW-1:0] cur_idx;
    logic            wr_en;

    bt_decode #(
        .MEM_BASE (MEM_BASE),
        .MEM_WORDS(MEM_WORDS),
        .IO_BASE  (IO_BASE),
        .IO_WORDS (IO_WORDS),
        .IDXW     (IDXW)
    ) u_decode (
        .addr     (addr_data_in),
        .cmd      (cmd_be_n),
        .claim    (start_claim),
        .start_idx(start_idx)
    );

    bt_phase_ctl #(
        .MEM_WORDS(MEM_WORDS),
        .IDXW     (IDXW)
    ) u_ctl (
        .clk           (clk),
        .rst           (rst),
        .bus_cyc_n     (bus_cyc_n),
        .init_ready_n  (init_ready_n),
        .start_claim   (start_claim),
        .start_idx     (start_idx),
        .claim_n       (claim_n),
        .target_ready_n(target_ready_n),
        .stop_req_n    (stop_req_n),
        .read_oe       (addr_data_oe),
        .wr_en         (wr_en),
        .cur_idx       (cur_idx)
    );

    bt_regfile #(
        .WORDS(WORDS),
        .IDXW (IDXW)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (cur_idx),
        .wr_data(addr_data_in),
        .wr_be  (~cmd_be_n),
        .rd_idx (cur_idx),
        .rd_data(addr_data_out)
    );

    // R1: idle bus outputs while reset is applied
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (claim_n && target_ready_n && stop_req_n && !addr_data_oe));

endmodule

// File: tb/mux_bus_target_bench.sv
`timescale 1ns/1ps
module mux_bus_target_bench;
    localparam logic [31:0] MB = 32'h0000_1000;
    localparam int          MW = 8;
    localparam logic [31:0] IB = 32'h0000_0300;
    localparam int          IW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cyc_n = 1'b1;
    logic        init_ready_n = 1'b1;
    logic [31:0] addr_data_in = '0;
    logic [3:0]  cmd_be_n = 4'hF;
    logic [31:0] addr_data_out;
    logic        addr_data_oe;
    logic        claim_n;
    logic        target_ready_n;
    logic        stop_req_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] model [MW+IW];

    always #4 clk = ~clk;

    mux_bus_target #(.MEM_BASE(MB), .MEM_WORDS(MW), .IO_BASE(IB), .IO_WORDS(IW)) u_mux_bus_target (
        .clk(clk), .rst(rst), .bus_cyc_n(bus_cyc_n), .init_ready_n(init_ready_n),
        .addr_data_in(addr_data_in), .cmd_be_n(cmd_be_n), .addr_data_out(addr_data_out),
        .addr_data_oe(addr_data_oe), .claim_n(claim_n), .target_ready_n(target_ready_n),
        .stop_req_n(stop_req_n));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit is_mrd(input logic [3:0] c);
        return c == 4'h6 || c == 4'hC || c == 4'hE;
    endfunction
    function automatic bit is_mwr(input logic [3:0] c);
        return c == 4'h7 || c == 4'hF;
    endfunction

    // One transaction of n intended phases; waits inserts an idle initiator cycle before phase 0.
    task automatic xfer(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                        input logic [3:0] be_n, input logic [31:0] seed, input bit waits);
        bit in_m, in_i, hit, wr, io;
        int idx;
        logic [31:0] dat;
        in_m = (addr >= MB) && (addr < MB + 32'(MW*4));
        in_i = (addr >= IB) && (addr < IB + 32'(IW*4));
        io   = in_i && (cmd == 4'h2 || cmd == 4'h3);
        hit  = io || (in_m && (is_mrd(cmd) || is_mwr(cmd)));
        wr   = io ? (cmd == 4'h3) : is_mwr(cmd);
        idx  = io ? MW + int'((addr - IB) >> 2) : int'((addr - MB) >> 2);
        @(negedge clk);
        bus_cyc_n = 1'b0; init_ready_n = 1'b1; addr_data_in = addr; cmd_be_n = cmd;
        @(negedge clk);
        chk(claim_n == !hit, hit ? "R2" : "R3", "claim after start", 32'(claim_n), 32'(!hit));
        if (!hit) begin
            bus_cyc_n = 1'b1;
            @(negedge clk);
            chk(claim_n && target_ready_n, "R3", "unclaimed stays quiet", 32'(claim_n), 32'd1);
            return;
        end
        if (waits) begin
            addr_data_in = 32'hDEAD_BEEF; cmd_be_n = 4'h0;
            @(negedge clk);
            chk(!target_ready_n && !claim_n, "R4", "ready during initiator wait",
                32'(target_ready_n), 32'd0);
            if (!wr) chk(addr_data_out == model[idx], "R4", "word held over wait",
                         addr_data_out, model[idx]);
        end
        for (int k = 0; k < n; k++) begin
            bit last, stp;
            last = (k == n - 1);
            stp  = io || (idx == MW - 1);
            chk(!target_ready_n && !claim_n, "R2", "ready in data phase", 32'(target_ready_n), 32'd0);
            chk(stop_req_n == !stp, stp ? (io ? "R9" : "R8") : "R7", "stop indication",
                32'(stop_req_n), 32'(!stp));
            if (!wr) begin
                chk(addr_data_oe == 1'b1, "R2", "read output enable", 32'(addr_data_oe), 32'd1);
                chk(addr_data_out == model[idx], is_mrd(cmd) && cmd != 4'h6 ? "R10" : "R7",
                    "read word", addr_data_out, model[idx]);
            end
            dat = seed + 32'(k) * 32'h0101_0101;
            addr_data_in = dat; cmd_be_n = be_n; init_ready_n = 1'b0; bus_cyc_n = last;
            if (wr) for (int b = 0; b < 4; b++)
                if (!be_n[b]) model[idx][8*b +: 8] = dat[8*b +: 8];
            @(negedge clk);
            if (last) begin
                bus_cyc_n = 1'b1; init_ready_n = 1'b1;
                chk(claim_n && target_ready_n && stop_req_n, "R6", "release after final",
                    {29'd0, claim_n, target_ready_n, stop_req_n}, 32'd7);
                return;
            end
            if (stp) begin
                chk(target_ready_n && !stop_req_n && !claim_n, stp && io ? "R9" : "R8",
                    "hold after stop", {29'd0, claim_n, target_ready_n, stop_req_n}, 32'd2);
                bus_cyc_n = 1'b1; init_ready_n = 1'b1;
                @(negedge clk);
                chk(claim_n && stop_req_n, "R8", "hold released", 32'(stop_req_n), 32'd1);
                return;
            end
            idx++;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MW + IW; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk(claim_n && target_ready_n && stop_req_n && !addr_data_oe, "R1", "outputs in reset",
            {28'd0, claim_n, target_ready_n, stop_req_n, addr_data_oe}, 32'hE);
        rst = 1'b0;
        @(negedge clk);
        chk(claim_n && target_ready_n && stop_req_n && !addr_data_oe, "R1", "outputs after reset",
            {28'd0, claim_n, target_ready_n, stop_req_n, addr_data_oe}, 32'hE);
        // R1: whole memory window reads zero; R7 sequencing, R8 at its end
        xfer(4'h6, MB, MW, 4'h0, '0, 1'b0);
        for (int i = 0; i < IW; i++) xfer(4'h2, IB + 32'(4*i), 1, 4'h0, '0, 1'b0);
        // R7/R8: write bursts from every start offset, some crossing the window end
        for (int s = 0; s < MW; s++)
            xfer(4'h7, MB + 32'(4*s) + 32'(s % 4), 3, 4'h0, 32'h1111_0000 * 32'(s + 1), s[0]);
        xfer(4'h6, MB, MW, 4'h0, '0, 1'b1);
        // R9: I/O burst attempts end after one word
        for (int i = 0; i < IW; i++) xfer(4'h3, IB + 32'(4*i), 2, 4'h0, 32'hA500_0000 + 32'(i), i[0]);
        for (int i = 0; i < IW; i++) xfer(4'h2, IB + 32'(4*i), 1, 4'h0, '0, 1'b0);
        // R5: every byte-enable pattern on one word
        for (int b = 0; b < 16; b++) begin
            xfer(4'h7, MB + 32'd12, 1, 4'h0, 32'hFFFF_FFFF, 1'b0);
            xfer(4'h7, MB + 32'd12, 1, 4'(b), 32'h0000_0000, 1'b0);
            xfer(4'h6, MB + 32'd12, 1, 4'h0, '0, 1'b0);
        end
        // R2/R3/R10: all command codes against both windows
        for (int c = 0; c < 16; c++) begin
            xfer(4'(c), MB + 32'd16, 1, 4'h0, 32'hC0DE_0000 + 32'(c), 1'b0);
            xfer(4'h6, MB + 32'd16, 1, 4'h0, '0, 1'b0);
            xfer(4'(c), IB + 32'd4, 1, 4'h0, 32'h0D10_0000 + 32'(c), 1'b0);
            xfer(4'h2, IB + 32'd4, 1, 4'h0, '0, 1'b0);
        end
        // R3: addresses just outside each window
        xfer(4'h7, MB - 32'd4, 1, 4'h0, 32'h1234_5678, 1'b0);
        xfer(4'h7, MB + 32'(MW*4), 1, 4'h0, 32'h1234_5678, 1'b0);
        xfer(4'h3, IB + 32'(IW*4), 1, 4'h0, 32'h1234_5678, 1'b0);
        xfer(4'h6, MB, MW, 4'h0, '0, 1'b0);
        for (int i = 0; i < IW; i++) xfer(4'h2, IB + 32'(4*i), 1, 4'h0, '0, 1'b0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule